// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small bank of system control registers on a 32-bit register bus. It has a word address, a write strobe with write data, and a read strobe with registered read data. Its main job is to hold the reset and clock-stop requests for two processor cores. It turns each pair of requests into a per-core halt line and a per-core reset line.

The control register is guarded by a write lock, and the block leaves reset with the lock engaged. Software releases the lock by writing a specific 16-bit unlock key to a dedicated unlock slot. It engages the lock again by writing a different 16-bit key to a dedicated lock slot. A wrong key is rejected and leaves the lock unchanged. A wrong key, or a write to the core-control register while locked, sets a sticky error flag. Software clears the flag by writing a 1 to it.

The bank also returns a set of fixed clock-configuration words, so that boot software sees a plausible clock setup. Every other offset in the 4 KiB window reads as zero and ignores writes.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: After reset the lock is engaged, every core reset and clock-stop bit is 0, both halt outputs and both reset outputs are 0, and the error flag is 0.
- R2: A write to byte offset 0x004 whose bits 15:0 equal 0x767B engages the lock, and bits 31:16 are ignored. Any other low half leaves the lock state unchanged.
- R3: A write to byte offset 0x008 whose bits 15:0 equal 0xDF0D releases the lock, and bits 31:16 are ignored. Any other low half leaves the lock state unchanged.
- R4: Offset 0x00C returns the lock state in bit 0 (1 = locked) and zero in bits 31:1. Offsets 0x004 and 0x008 read as zero.
- R5: Offset 0x244 is the core-control register: bit 0 is the core 0 reset request, bit 1 the core 1 reset request, bit 4 the core 0 clock-stop request and bit 5 the core 1 clock-stop request. A write while unlocked loads these four bits, and every other bit reads as zero.
- R6: While the lock is engaged, a write to offset 0x244 changes none of the reset or clock-stop bits.
- R7: From the clock edge that stores the core-control write onward, core n's reset output equals its reset bit, and its halt output equals the OR of its reset and clock-stop bits.
- R8: The fixed words read as follows: 0x100, 0x104 and 0x108 return 0x0001A008; 0x10C returns 0x0000003F; 0x120 returns 0x1F000400; 0x124 returns 0x18400003; 0x12C returns 0x01FFCCCD; 0x150 returns 0x00001E03; 0x154 returns 0x00003F03; 0x1C4 returns 0x00000001.
- R9: Writes to the fixed words, to 0x00C and to any unlisted offset have no effect. Every unlisted offset in the 0x1000-byte window reads as zero.
- R10: Offset 0x010 bit 0 is a sticky error flag. It is set by a wrong key at 0x004 or 0x008, or by any write to 0x244 while locked. A write to 0x010 with bit 0 = 1 clears it, a write with bit 0 = 0 leaves it, and bits 31:1 read zero.
- R11: Address bits 1:0 are ignored. Read data appears on the edge that samples the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W (12) | Byte address inside the window |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| halt_o | output | NUM_CORES (2) | Per-core halt request |
| core_rst_o | output | NUM_CORES (2) | Per-core reset hold |

## Verification
The bench reads every word in the window three times: while locked, after unlocking, and after writing all ones everywhere. A decoder that aliases offsets, drops a fixed word or lets a write stick to a read-only slot would show a wrong word at that offset.

It tries near-miss keys in both slots, keys with garbage in the upper half, and writes to the control register while locked. A design that compares all 32 bits, accepts a wrong key or leaks a locked write would leave the lock or the core bits in the wrong state, or miss the error flag.

All 64 combinations of the four control bits and the reserved-bit noise are written. A design that swaps the two cores, reads reserved bits back, or builds halt from only one of its two causes would show the wrong outputs on the cycle after the write.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_CORES = 4;

  // Bit positions of the per-core fields inside the core-control word
  localparam int unsigned CORE_RST_LSB  = 0;
  localparam int unsigned CORE_STOP_LSB = 4;

  localparam logic [15:0] KEY_ENGAGE  = 16'h767B;
  localparam logic [15:0] KEY_RELEASE = 16'hDF0D;

  localparam logic [31:0] OFS_ENGAGE  = 32'h004;
  localparam logic [31:0] OFS_RELEASE = 32'h008;
  localparam logic [31:0] OFS_STATUS  = 32'h00C;
  localparam logic [31:0] OFS_ERROR   = 32'h010;
  localparam logic [31:0] OFS_CORES   = 32'h244;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENGAGE,
    SEL_RELEASE,
    SEL_STATUS,
    SEL_ERROR,
    SEL_CORES,
    SEL_FIXED
  } sel_e;

  typedef struct packed {
    logic              hit;
    logic [DATA_W-1:0] value;
  } fixed_t;

  // Constant clock-configuration words, keyed by aligned byte offset
  function automatic fixed_t fixed_lookup(input logic [31:0] ofs);
    fixed_t r;
    r.hit = 1'b1;
    case (ofs)
      32'h100, 32'h104, 32'h108: r.value = 32'h0001_A008;
      32'h10C:                   r.value = 32'h0000_003F;
      32'h120:                   r.value = 32'h1F00_0400;
      32'h124:                   r.value = 32'h1840_0003;
      32'h12C:                   r.value = 32'h01FF_CCCD;
      32'h150:                   r.value = 32'h0000_1E03;
      32'h154:                   r.value = 32'h0000_3F03;
      32'h1C4:                   r.value = 32'h0000_0001;
      default: begin
        r.hit   = 1'b0;
        r.value = '0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [DATA_W-1:0] fixed_o
);

  localparam int unsigned WORD_LSB = 2;

  logic [31:0] ofs;
  fixed_t      fx;
  logic        unused_lsb;

  assign unused_lsb = ^addr_i[WORD_LSB-1:0];
  assign ofs        = 32'({addr_i[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}});
  assign fx         = fixed_lookup(ofs);
  assign fixed_o    = fx.value;

  always_comb begin
    if (ofs == OFS_ENGAGE)       sel_o = SEL_ENGAGE;
    else if (ofs == OFS_RELEASE) sel_o = SEL_RELEASE;
    else if (ofs == OFS_STATUS)  sel_o = SEL_STATUS;
    else if (ofs == OFS_ERROR)   sel_o = SEL_ERROR;
    else if (ofs == OFS_CORES)   sel_o = SEL_CORES;
    else if (fx.hit)             sel_o = SEL_FIXED;
    else                         sel_o = SEL_NONE;
  end

endmodule

// File: rtl/sysctl_lock_ctrl.sv
`timescale 1ns/1ps
module sysctl_lock_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o,
  output logic              err_o
);

  logic locked_q, err_q;
  logic engage_ok, release_ok, bad_key, blocked, err_clr;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:16];

  assign engage_ok  = wr_en_i && sel_i == SEL_ENGAGE  && wdata_i[15:0] == KEY_ENGAGE;
  assign release_ok = wr_en_i && sel_i == SEL_RELEASE && wdata_i[15:0] == KEY_RELEASE;
  assign bad_key    = wr_en_i && ((sel_i == SEL_ENGAGE  && wdata_i[15:0] != KEY_ENGAGE) ||
                                  (sel_i == SEL_RELEASE && wdata_i[15:0] != KEY_RELEASE));
  assign blocked    = wr_en_i && sel_i == SEL_CORES && locked_q;
  assign err_clr    = wr_en_i && sel_i == SEL_ERROR && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      if (engage_ok)       locked_q <= 1'b1;
      else if (release_ok) locked_q <= 1'b0;
      if (bad_key || blocked) err_q <= 1'b1;
      else if (err_clr)       err_q <= 1'b0;
    end
  end

  assign locked_o = locked_q;
  assign err_o    = err_q;

  assert_engage_key_locks_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel_i == SEL_ENGAGE && wdata_i[15:0] == 16'h767B) |=> locked_q)
    else $error("engage key did not lock");

  assert_release_key_unlocks_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel_i == SEL_RELEASE && wdata_i[15:0] == 16'hDF0D) |=> !locked_q)
    else $error("release key did not unlock");

  assert_lock_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(locked_q))
    else $error("lock moved without a write");

  assert_bad_key_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel_i == SEL_RELEASE && wdata_i[15:0] != 16'hDF0D) |=> (err_q && $stable(locked_q)))
    else $error("wrong release key not flagged");

endmodule

// File: rtl/sysctl_core_ctrl.sv
`timescale 1ns/1ps
module sysctl_core_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_req_i,
  input  logic                 locked_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    view_o,
  output logic [NUM_CORES-1:0] halt_o,
  output logic [NUM_CORES-1:0] core_rst_o
);

  logic [NUM_CORES-1:0] rst_q, stop_q, halt_q;
  logic                 upd;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign upd          = wr_req_i && !locked_i;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) begin
        rst_q[c]  <= 1'b0;
        stop_q[c] <= 1'b0;
        halt_q[c] <= 1'b0;
      end else if (upd) begin
        rst_q[c]  <= wdata_i[CORE_RST_LSB + c];
        stop_q[c] <= wdata_i[CORE_STOP_LSB + c];
        halt_q[c] <= wdata_i[CORE_RST_LSB + c] | wdata_i[CORE_STOP_LSB + c];
      end
    end
  end

  always_comb begin
    view_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      view_o[CORE_RST_LSB + c]  = rst_q[c];
      view_o[CORE_STOP_LSB + c] = stop_q[c];
    end
  end

  assign halt_o     = halt_q;
  assign core_rst_o = rst_q;

  assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_req_i && locked_i) |=> ($stable(rst_q) && $stable(stop_q)))
    else $error("core bits changed while locked");

  assert_halt_tracks_causes_R7: assert property (@(posedge clk) disable iff (rst)
    halt_q == (rst_q | stop_q))
    else $error("halt disagrees with reset/stop bits");

  assert_bits_hold_without_write_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_req_i |=> ($stable(rst_q) && $stable(stop_q)))
    else $error("core bits moved without a write");

endmodule

// File: rtl/sysctl_keyed_regs.sv
`timescale 1ns/1ps
module sysctl_keyed_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          wdata_i,
  input  logic                 rd_en_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CORES-1:0] halt_o,
  output logic [NUM_CORES-1:0] core_rst_o
);

  // NUM_CORES must not exceed MAX_CORES so reset and stop fields stay apart
  sel_e              sel;
  logic [DATA_W-1:0] fixed_word;
  logic [DATA_W-1:0] core_view;
  logic              locked, err;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i  (addr_i),
    .sel_o   (sel),
    .fixed_o (fixed_word)
  );

  sysctl_lock_ctrl u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .locked_o (locked),
    .err_o    (err)
  );

  sysctl_core_ctrl #(.NUM_CORES(NUM_CORES)) u_cores (
    .clk        (clk),
    .rst        (rst),
    .wr_req_i   (wr_en_i && sel == SEL_CORES),
    .locked_i   (locked),
    .wdata_i    (wdata_i),
    .view_o     (core_view),
    .halt_o     (halt_o),
    .core_rst_o (core_rst_o)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: rd_mux = {{(DATA_W-1){1'b0}}, locked};
      SEL_ERROR:  rd_mux = {{(DATA_W-1){1'b0}}, err};
      SEL_CORES:  rd_mux = core_view;
      SEL_FIXED:  rd_mux = fixed_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_q))
    else $error("read data moved without a read");

  assert_status_reports_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel == SEL_STATUS) |=> (rdata_q == {31'b0, $past(locked)}))
    else $error("status read disagrees with lock");

endmodule

// File: tb/test_sysctl_keyed_regs.sv
`timescale 1ns/1ps
module test_sysctl_keyed_regs;

  localparam int ADDR_W = 12;
  localparam int NC     = 2;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wdata = '0;
  logic              rd_en = 1'b0;
  logic [31:0]       rdata;
  logic [NC-1:0]     halt, crst;

  always #2.5 clk = ~clk;

  sysctl_keyed_regs #(.ADDR_W(ADDR_W), .NUM_CORES(NC)) i_sysctl_keyed_regs (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .halt_o(halt), .core_rst_o(crst)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // Reference model
  bit       m_lock = 1;
  bit       m_err  = 0;
  bit [1:0] m_rst  = 0;
  bit [1:0] m_stop = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int ofs);
    case (ofs)
      'h00C: return {31'b0, m_lock};
      'h010: return {31'b0, m_err};
      'h244: return {26'b0, m_stop, 2'b00, m_rst};
      'h100, 'h104, 'h108: return 32'h0001A008;
      'h10C: return 32'h0000003F;
      'h120: return 32'h1F000400;
      'h124: return 32'h18400003;
      'h12C: return 32'h01FFCCCD;
      'h150: return 32'h00001E03;
      'h154: return 32'h00003F03;
      'h1C4: return 32'h00000001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int ofs);
    case (ofs)
      'h004, 'h008, 'h00C: return "R4";
      'h010: return "R10";
      'h244: return "R5";
      'h100, 'h104, 'h108, 'h10C, 'h120, 'h124, 'h12C, 'h150, 'h154, 'h1C4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rdata;
  endtask

  // Write through the bus and update the model from the requirements
  task automatic bwr(logic [ADDR_W-1:0] a, logic [31:0] d);
    int ofs;
    ofs = int'(a) & ~3;
    case (ofs)
      'h004: if (d[15:0] == 16'h767B) m_lock = 1; else m_err = 1;
      'h008: if (d[15:0] == 16'hDF0D) m_lock = 0; else m_err = 1;
      'h010: if (d[0]) m_err = 0;
      'h244: if (m_lock) m_err = 1;
             else begin m_rst = {d[1], d[0]}; m_stop = {d[5], d[4]}; end
      default: ;
    endcase
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk_outs(string req);
    chk({req, " reset out"}, 32'(crst), 32'(m_rst));
    chk({req, " halt out"},  32'(halt), 32'(m_rst | m_stop));
  endtask

  task automatic sweep();
    logic [31:0] v;
    for (int w = 0; w < WORDS; w++) begin
      rd(ADDR_W'(w * 4), v);
      chk(tag_of(w * 4), v, exp_word(w * 4));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 halt", 32'(halt), 0);
    chk("R1 reset", 32'(crst), 0);
    rd(12'h00C, v); chk("R1 locked", v, 1);
    rd(12'h010, v); chk("R1 error", v, 0);
    rd(12'h244, v); chk("R1 core bits", v, 0);

    // Full map while locked (R4, R8, R9)
    sweep();

    // R6 / R10: locked write to core control
    bwr(12'h244, 32'hFFFF_FFFF);
    chk_outs("R6");
    rd(12'h244, v); chk("R6 core bits", v, exp_word('h244));
    rd(12'h010, v); chk("R10 set by locked write", v, 1);
    bwr(12'h010, 32'h0000_0000);
    rd(12'h010, v); chk("R10 zero write keeps", v, 1);
    bwr(12'h010, 32'h0000_0001);
    rd(12'h010, v); chk("R10 cleared", v, 0);

    // R3: near-miss release keys
    bwr(12'h008, 32'h0000_DF0C);
    rd(12'h00C, v); chk("R3 wrong key kept lock", v, 1);
    rd(12'h010, v); chk("R10 wrong key flag", v, 1);
    bwr(12'h008, 32'hDF0D_0000);
    rd(12'h00C, v); chk("R3 key in upper half", v, 1);
    bwr(12'h004, 32'h0000_DF0D);
    rd(12'h00C, v); chk("R3 key in wrong slot", v, 1);
    bwr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R10 cleared again", v, 0);
    bwr(12'h008, 32'hABCD_DF0D);
    rd(12'h00C, v); chk("R3 unlock with noise", v, 0);
    rd(12'h010, v); chk("R10 good key no flag", v, 0);

    // R5 / R7: every control-bit combination with reserved noise
    for (int p = 0; p < 64; p++) begin
      logic [31:0] d;
      d = {26'b0, p[3], p[2], 2'b00, p[1], p[0]};
      if (p[4]) d = d | 32'hFFFF_FFCC;
      if (p[5]) d = d | 32'h0000_000C;
      bwr(12'h244, d);
      chk_outs("R7");
      rd(12'h244, v); chk("R5 readback", v, exp_word('h244));
    end

    // R11: unaligned address and data hold
    bwr(12'h244, 32'h0000_0021);
    chk_outs("R7");
    rd(12'h247, v); chk("R11 unaligned core read", v, 32'h0000_0021);
    rd(12'h10E, v); chk("R11 unaligned fixed read", v, 32'h0000_003F);
    @(negedge clk); addr = 12'h244;
    repeat (3) @(negedge clk);
    chk("R11 data holds", rdata, 32'h0000_003F);

    // R9: write ones everywhere else, then re-check the map
    for (int w = 0; w < WORDS; w++) begin
      if (w * 4 != 'h004 && w * 4 != 'h008 && w * 4 != 'h010 && w * 4 != 'h244)
        bwr(ADDR_W'(w * 4), 32'hFFFF_FFFF);
    end
    sweep();

    // R2: near-miss engage key, then real one
    bwr(12'h004, 32'h0000_767A);
    rd(12'h00C, v); chk("R2 wrong key kept unlock", v, 0);
    rd(12'h010, v); chk("R10 wrong engage flag", v, 1);
    bwr(12'h004, 32'h5555_767B);
    rd(12'h00C, v); chk("R2 locked with noise", v, 1);

    // R6 again: locked writes hold outputs
    bwr(12'h244, 32'h0000_0000);
    chk_outs("R6");
    rd(12'h244, v); chk("R6 bits held", v, 32'h0000_0021);

    // Release, clear resets, check release timing
    bwr(12'h008, 32'h0000_DF0D);
    bwr(12'h244, 32'h0000_0010);
    chk_outs("R7");
    chk("R7 core0 released", 32'(crst), 0);
    sweep();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule